// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank State Tracking

This block sits on the device side of the command bus of a four-bank synchronous DRAM with a 12-bit address bus. On every rising clock edge it samples chip select, the three strobe lines (RAS#, CAS#, WE#), the two-bit bank address, the address bus and the clock enable. It decodes the command and keeps an idle or active flag and an open row for each bank. It also tracks pending auto-precharge operations, latches the column, bank and auto-precharge flag of each accepted read or write, and captures the mode register opcode.

Its outputs are one-cycle command strobes, an illegal-command strobe, the per-bank state and open rows, the last column access, and a burst address that walks through the burst. Clock suspend and power-down are reported as status levels. When the clock enable is sampled low, the block stops all internal updates from the next edge onwards. Any larger memory model or controller checker is built on top of these outputs.

Top module: `sdc_cmd_decoder`

## Requirements
- R1: While reset is asserted, and right after it is released, every bank is idle, every open row and captured field is zero, the burst address is zero and no strobe is high.
- R2: A command sampled with cs_n high, or the refresh code (RAS# low, CAS# low, WE# high), raises no strobe and changes no bank state, row, column field or mode opcode.
- R3: RAS# low, CAS# high, WE# high activates the bank named by ba, where 0, 1, 2 and 3 select banks A, B, C and D (bit index ba of bank_active, row bits [ba*12 +: 12] of open_rows). The bank becomes active and its row is taken from addr. act_stb is high for the cycle after the edge.
- R4: RAS# low, CAS# high, WE# low is a precharge. With addr[10] low it idles only bank ba. With addr[10] high it idles all four banks. pre_stb is high for one cycle.
- R5: RAS# high, CAS# low starts a column access: WE# high is a read (rd_stb) and WE# low is a write (wr_stb). col_addr takes addr[7:0], col_bank takes ba and auto_pre takes addr[10].
- R6: A read or write with addr[10] high leaves its bank active for the burst. The bank goes idle on the fourth enabled edge after the command. A read or write to that bank before then is illegal.
- R7: An accepted read or write loads burst_addr with the column. burst_addr then increments by one on each of the next three enabled edges and holds after that.
- R8: If cke is sampled low at edge N, the command at edge N still executes. From edge N+1 until the edge after cke is sampled high again, commands are ignored, all strobes are low, and bank state and burst_addr are frozen. clk_susp is high during that window.
- R9: pwr_down is high exactly when the clock is suspended and all banks are idle.
- R10: RAS#, CAS# and WE# all low is a mode register set. It is accepted only when all banks are idle: mrs_stb is raised and mode_op takes addr.
- R11: An activate to an active bank, a read or write to an idle bank, or a mode register set while any bank is active raises illegal_stb for one cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row, column or opcode; bit 10 is the auto/all flag |
| act_stb | output | 1 | Activate accepted |
| pre_stb | output | 1 | Precharge accepted |
| rd_stb | output | 1 | Read accepted |
| wr_stb | output | 1 | Write accepted |
| mrs_stb | output | 1 | Mode register set accepted |
| illegal_stb | output | 1 | Command rejected for bank state |
| bank_active | output | 4 | Per-bank active flag, bit 0 is bank A |
| open_rows | output | 48 | Row per bank, 12 bits each, bank A lowest |
| col_addr | output | 8 | Column of last accepted read/write |
| col_bank | output | 2 | Bank of last accepted read/write |
| auto_pre | output | 1 | Auto-precharge flag of last read/write |
| mode_op | output | 12 | Last accepted mode register opcode |
| burst_addr | output | 8 | Current burst column |
| clk_susp | output | 1 | Internal clock suspended |
| pwr_down | output | 1 | Suspended with every bank idle |

## Verification
A bank flag that is wrong inside the block reaches bank_active on the edge after the faulty update. The next command to that bank then shows it a second time: illegal_stb rises where an act_stb or rd_stb was due, or the reverse. An auto-precharge countdown of the wrong length moves the cycle in which a bank drops idle, and the same-bank write placed inside the window flags it immediately. A broken clock-enable path shows up within one cycle as a strobe, burst step or bank change during a suspended cycle.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_PRE,
    CMD_RD,
    CMD_WR,
    CMD_MRS,
    CMD_REF
  } cmd_e;
endpackage

// File: rtl/sdc_cmd_classify.sv
`timescale 1ns/1ps
module sdc_cmd_classify
  import sdc_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = CMD_PRE;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdc_bank_slot.sv
`timescale 1ns/1ps
module sdc_bank_slot #(
  parameter int ROW_W     = 12,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             act_go,
  input  logic             pre_go,
  input  logic             ap_go,
  input  logic [ROW_W-1:0] row_in,
  output logic             active,
  output logic             busy,
  output logic [ROW_W-1:0] row
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_d;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    act_d = active;
    cnt_d = cnt_q;
    row_d = row;
    if (pre_go) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (act_go) begin
      act_d = 1'b1;
      row_d = row_in;
    end else if (ap_go) begin
      cnt_d = CNT_W'(BURST_LEN);
    end else if (en && cnt_q != '0) begin
      if (cnt_q == CNT_W'(1)) act_d = 1'b0;
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
      row    <= '0;
    end else begin
      active <= act_d;
      cnt_q  <= cnt_d;
      row    <= row_d;
    end
  end

  assign busy = (cnt_q != '0);

  assert_ap_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q == CNT_W'(1)) |=> !active);

  assert_activate_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> (active && row == $past(row_in)));
endmodule

// File: rtl/sdc_cmd_decoder.sv
`timescale 1ns/1ps
module sdc_cmd_decoder
  import sdc_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int BANK_W    = 2,
  parameter int BURST_LEN = 4,
  parameter int AP_BIT    = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cke,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic [BANK_W-1:0]             ba,
  input  logic [ROW_W-1:0]              addr,
  output logic                          act_stb,
  output logic                          pre_stb,
  output logic                          rd_stb,
  output logic                          wr_stb,
  output logic                          mrs_stb,
  output logic                          illegal_stb,
  output logic [(1<<BANK_W)-1:0]        bank_active,
  output logic [(1<<BANK_W)*ROW_W-1:0]  open_rows,
  output logic [COL_W-1:0]              col_addr,
  output logic [BANK_W-1:0]             col_bank,
  output logic                          auto_pre,
  output logic [ROW_W-1:0]              mode_op,
  output logic [COL_W-1:0]              burst_addr,
  output logic                          clk_susp,
  output logic                          pwr_down
);
  localparam int NBANK = 1 << BANK_W;
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  cmd_e             cmd;
  logic             cke_q;
  logic [NBANK-1:0] busy, act_go, pre_go, ap_go;
  logic             all_idle, sel_act, sel_busy, is_col;
  logic             act_ok, pre_ok, col_ok, mrs_ok, bad;
  logic [COL_W-1:0] burst_d;
  logic [CNT_W-1:0] beats_q, beats_d;

  sdc_cmd_classify u_classify (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd)
  );

  // legality against the state before this edge
  always_comb begin
    all_idle = (bank_active == '0);
    sel_act  = bank_active[ba];
    sel_busy = busy[ba];
    is_col   = (cmd == CMD_RD) || (cmd == CMD_WR);
    act_ok   = cke_q && (cmd == CMD_ACT) && !sel_act;
    pre_ok   = cke_q && (cmd == CMD_PRE);
    col_ok   = cke_q && is_col && sel_act && !sel_busy;
    mrs_ok   = cke_q && (cmd == CMD_MRS) && all_idle;
    bad      = cke_q && (((cmd == CMD_ACT) && sel_act) ||
                         (is_col && !(sel_act && !sel_busy)) ||
                         ((cmd == CMD_MRS) && !all_idle));
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign act_go[b] = act_ok && (ba == BANK_W'(b));
    assign pre_go[b] = pre_ok && (addr[AP_BIT] || (ba == BANK_W'(b)));
    assign ap_go[b]  = col_ok && addr[AP_BIT] && (ba == BANK_W'(b));

    sdc_bank_slot #(
      .ROW_W    (ROW_W),
      .BURST_LEN(BURST_LEN)
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cke_q),
      .act_go(act_go[b]),
      .pre_go(pre_go[b]),
      .ap_go (ap_go[b]),
      .row_in(addr),
      .active(bank_active[b]),
      .busy  (busy[b]),
      .row   (open_rows[b*ROW_W +: ROW_W])
    );
  end

  // burst walker
  always_comb begin
    burst_d = burst_addr;
    beats_d = beats_q;
    if (col_ok) begin
      burst_d = addr[COL_W-1:0];
      beats_d = CNT_W'(BURST_LEN - 1);
    end else if (cke_q && beats_q != '0) begin
      burst_d = burst_addr + COL_W'(1);
      beats_d = beats_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q       <= 1'b1;
      act_stb     <= 1'b0;
      pre_stb     <= 1'b0;
      rd_stb      <= 1'b0;
      wr_stb      <= 1'b0;
      mrs_stb     <= 1'b0;
      illegal_stb <= 1'b0;
      col_addr    <= '0;
      col_bank    <= '0;
      auto_pre    <= 1'b0;
      mode_op     <= '0;
      burst_addr  <= '0;
      beats_q     <= '0;
    end else begin
      cke_q       <= cke;
      act_stb     <= act_ok;
      pre_stb     <= pre_ok;
      rd_stb      <= col_ok && (cmd == CMD_RD);
      wr_stb      <= col_ok && (cmd == CMD_WR);
      mrs_stb     <= mrs_ok;
      illegal_stb <= bad;
      burst_addr  <= burst_d;
      beats_q     <= beats_d;
      if (col_ok) begin
        col_addr <= addr[COL_W-1:0];
        col_bank <= ba;
        auto_pre <= addr[AP_BIT];
      end
      if (mrs_ok) mode_op <= addr;
    end
  end

  assign clk_susp = !cke_q;
  assign pwr_down = !cke_q && all_idle;

  assert_susp_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> !(act_stb || pre_stb || rd_stb || wr_stb || mrs_stb || illegal_stb));

  assert_susp_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> ($stable(bank_active) && $stable(burst_addr)));

  assert_mrs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_stb |-> (bank_active == '0));

  assert_illegal_keeps_rows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_stb |-> $stable(open_rows));
endmodule

// File: tb/sdc_cmd_decoder_tb.sv
`timescale 1ns/1ps
module sdc_cmd_decoder_tb;
  localparam logic [2:0] C_ACT = 3'b011, C_PRE = 3'b010, C_RD = 3'b101,
                         C_WR  = 3'b100, C_MRS = 3'b000, C_REF = 3'b001,
                         C_NOP = 3'b111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic act_stb, pre_stb, rd_stb, wr_stb, mrs_stb, illegal_stb;
  logic [3:0] bank_active;
  logic [47:0] open_rows;
  logic [7:0] col_addr, burst_addr;
  logic [1:0] col_bank;
  logic auto_pre, clk_susp, pwr_down;
  logic [11:0] mode_op;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sdc_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .act_stb(act_stb), .pre_stb(pre_stb), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .mrs_stb(mrs_stb), .illegal_stb(illegal_stb), .bank_active(bank_active),
    .open_rows(open_rows), .col_addr(col_addr), .col_bank(col_bank),
    .auto_pre(auto_pre), .mode_op(mode_op), .burst_addr(burst_addr),
    .clk_susp(clk_susp), .pwr_down(pwr_down)
  );

  typedef struct {
    string      tag;
    logic [96:0] vec;
  } exp_t;
  exp_t exp_q[$];

  function automatic logic [96:0] observed();
    return {act_stb, pre_stb, rd_stb, wr_stb, mrs_stb, illegal_stb, bank_active,
            open_rows, col_addr, col_bank, auto_pre, mode_op, burst_addr,
            clk_susp, pwr_down};
  endfunction

  // reference model built from the requirements
  logic        m_ckeq = 1'b1;
  logic [3:0]  m_act = '0;
  logic [11:0] m_row [4] = '{default: '0};
  int          m_cnt [4] = '{default: 0};
  logic [7:0]  m_col = '0, m_burst = '0;
  logic [1:0]  m_cb = '0;
  logic        m_ap = 1'b0;
  logic [11:0] m_mode = '0;
  int          m_beats = 0;

  task automatic step(input logic k, input logic cs, input logic [2:0] code,
                      input logic [1:0] b, input logic [11:0] a, input string tag);
    logic [5:0] stb;
    logic en, sa, sb, isc, aok, pok, cok, mok, bad;
    logic [47:0] rows;
    exp_t it;
    @(negedge clk);
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = code; ba = b; addr = a;
    stb = '0;
    en = m_ckeq;
    m_ckeq = k;
    if (en) begin
      sa  = m_act[b];
      sb  = (m_cnt[b] != 0);
      isc = !cs && (code == C_RD || code == C_WR);
      aok = !cs && code == C_ACT && !sa;
      pok = !cs && code == C_PRE;
      cok = isc && sa && !sb;
      mok = !cs && code == C_MRS && m_act == '0;
      bad = (!cs && code == C_ACT && sa) || (isc && !(sa && !sb)) ||
            (!cs && code == C_MRS && m_act != '0);
      stb = {aok, pok, cok && code == C_RD, cok && code == C_WR, mok, bad};
      for (int i = 0; i < 4; i++) begin
        if (pok && (a[10] || b == 2'(i))) begin
          m_act[i] = 1'b0; m_cnt[i] = 0;
        end else if (aok && b == 2'(i)) begin
          m_act[i] = 1'b1; m_row[i] = a;
        end else if (cok && a[10] && b == 2'(i)) begin
          m_cnt[i] = 4;
        end else if (m_cnt[i] != 0) begin
          if (m_cnt[i] == 1) m_act[i] = 1'b0;
          m_cnt[i]--;
        end
      end
      if (cok) begin
        m_col = a[7:0]; m_cb = b; m_ap = a[10]; m_burst = a[7:0]; m_beats = 3;
      end else if (m_beats != 0) begin
        m_burst++; m_beats--;
      end
      if (mok) m_mode = a;
    end
    rows = {m_row[3], m_row[2], m_row[1], m_row[0]};
    it.tag = tag;
    it.vec = {stb, m_act, rows, m_col, m_cb, m_ap, m_mode, m_burst,
              !m_ckeq, !m_ckeq && m_act == '0};
    exp_q.push_back(it);
  endtask

  // monitor: compare one item per edge, 1 ns after it
  initial forever begin
    @(posedge clk);
    #1;
    if (exp_q.size() != 0) begin
      exp_t it;
      it = exp_q.pop_front();
      checks++;
      if (observed() !== it.vec) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.tag, observed(), it.vec);
      end
    end
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (observed() !== '0) begin
      errors++;
      $display("FAIL R1 reset: got %h expected 0", observed());
    end
    rst_n = 1'b1;
    step(1, 1, C_NOP, 0, 12'h000, "R1 after release");
    step(1, 1, C_ACT, 0, 12'h3C3, "R2 deselected activate");
    step(1, 0, C_REF, 1, 12'h111, "R2 refresh code");
    step(1, 0, C_ACT, 0, 12'h123, "R3 activate bank A");
    step(1, 0, C_ACT, 3, 12'hABC, "R3 activate bank D");
    step(1, 0, C_ACT, 0, 12'h777, "R11 activate active bank");
    step(1, 0, C_RD,  2, 12'h010, "R11 read idle bank");
    step(1, 0, C_MRS, 0, 12'h055, "R10 R11 mode set while active");
    step(1, 0, C_RD,  0, 12'h05C, "R5 R7 read bank A");
    for (int i = 0; i < 4; i++) step(1, 1, C_NOP, 0, 0, "R7 burst walk");
    step(1, 0, C_WR,  3, 12'h4FE, "R5 R6 write auto precharge");
    step(1, 0, C_WR,  3, 12'h001, "R6 write during auto precharge");
    for (int i = 0; i < 3; i++) step(1, 1, C_NOP, 0, 0, "R6 bank closes");
    step(0, 0, C_ACT, 1, 12'h055, "R8 command on cke low edge");
    step(0, 0, C_ACT, 2, 12'h066, "R8 R9 ignored while suspended");
    step(1, 0, C_PRE, 0, 12'h400, "R8 ignored on re-enable edge");
    step(1, 0, C_RD,  1, 12'h020, "R7 read bank B");
    step(0, 1, C_NOP, 0, 0, "R8 burst before freeze");
    step(0, 1, C_NOP, 0, 0, "R8 burst frozen");
    step(1, 1, C_NOP, 0, 0, "R8 burst still frozen");
    step(1, 1, C_NOP, 0, 0, "R8 burst resumes");
    step(1, 0, C_PRE, 1, 12'h000, "R4 precharge bank B");
    step(1, 0, C_PRE, 2, 12'h400, "R4 precharge all");
    step(0, 1, C_NOP, 0, 0, "R9 enter power down");
    step(0, 0, C_MRS, 0, 12'h0AA, "R9 power down ignores mode set");
    step(1, 1, C_NOP, 0, 0, "R9 leave power down");
    step(1, 0, C_MRS, 0, 12'h237, "R10 mode set idle");
    step(1, 1, C_NOP, 0, 0, "R2 final idle");
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule